// File: doc/BRIEF.md
# Calibration DAC Loader

This block programs a bank of 8-bit trim DACs that share one serial clock line and one serial data line. It also drives a load strobe for those DACs. A client presents a channel number and a trim value for one cycle. The block first asks the controller of the serial memory that shares the same lines for the bus and waits for a grant. It then forces that memory's select and write-protect-release lines inactive and sends a 12-bit frame. The frame is the 4-bit channel followed by the 8-bit value, each field most significant bit first. Each bit is presented while the serial clock is low and is taken by the DAC on the rising clock edge. A separate high-then-low pulse on the load strobe latches the frame into the addressed DAC.

A per-channel shadow copy holds the value last loaded. Readback reads this copy and never touches the DAC. A request whose value already matches the shadow produces no serial traffic. After reset the block loads every channel with mid-scale on its own. While the block does not own the shared lines, the serial memory controller's clock, data, select and write-protect-release signals pass straight through to the pins.

Top module: `caldac_loader`

## Requirements
- R1: A load sends exactly 12 rising edges on `ser_clk`. The bits taken at those edges are `chan[3]..chan[0]` followed by `value[7]..value[0]`.
- R2: While the block owns the lines, `ser_data` does not change while `ser_clk` stays high.
- R3: While the block owns the lines, `eep_cs` and `eep_wp_rel` are low whatever the values of `ext_cs` and `ext_wp_rel`.
- R4: `dac_load` goes high once per frame, only after the 12th bit, with `ser_clk` low, and then returns low.
- R5: A request whose value equals the shadow value of its channel produces no clock edge and no load pulse, and `busy` stays low.
- R6: After reset, `busy` is high. Channels 0 to NUM_CHAN-1 (12 by default) are loaded with 0x80 in ascending order before `busy` first falls.
- R7: `rd_value` returns the shadow value of `rd_chan`, which is the value of the last completed load. It returns 0 for a channel at or above NUM_CHAN.
- R8: `busy` is high in the cycle after a request is accepted. It falls in the same cycle that `dac_load` falls. Any request made while `busy` is high is ignored.
- R9: No serial activity occurs until `bus_gnt` is high. `bus_req` stays high for as long as `busy` is high.
- R10: While the block does not own the lines, `ser_clk`, `ser_data`, `eep_cs` and `eep_wp_rel` follow `ext_sclk`, `ext_sdata`, `ext_cs` and `ext_wp_rel`.
- R11: A request for a channel at or above NUM_CHAN (12 to 15 by default) is dropped and causes no activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Load request strobe, one cycle |
| req_chan | input | 4 | Channel to load |
| req_value | input | 8 | Trim value to load |
| busy | output | 1 | Load or initial sweep in progress |
| rd_chan | input | 4 | Readback channel select |
| rd_value | output | 8 | Shadow value of `rd_chan` |
| bus_req | output | 1 | Request for the shared serial lines |
| bus_gnt | input | 1 | Grant of the shared serial lines |
| ext_sclk | input | 1 | Memory controller's serial clock |
| ext_sdata | input | 1 | Memory controller's serial data |
| ext_cs | input | 1 | Memory controller's select |
| ext_wp_rel | input | 1 | Memory controller's write-protect release |
| ser_clk | output | 1 | Shared serial clock pin |
| ser_data | output | 1 | Shared serial data pin |
| eep_cs | output | 1 | Serial memory select pin |
| eep_wp_rel | output | 1 | Serial memory write-protect release pin |
| dac_load | output | 1 | Trim DAC load strobe |

## Verification
The checks assume that the arbiter keeps `bus_gnt` high for as long as `bus_req` is high once it has granted the lines. Without that, a frame could be cut off. The bench's arbiter model copies `bus_req` onto `bus_gnt` one half-cycle later and is only disabled while no frame is in flight. The bench holds the external memory signals at constant levels whenever the block may own the lines. That way every clock edge the bench's frame monitor records comes from the loader alone.

// File: rtl/caldac_pkg.sv
`timescale 1ns/1ps
package caldac_pkg;
   typedef enum logic [1:0] {
      SQ_ARB   = 2'd0,
      SQ_PREP  = 2'd1,
      SQ_SHIFT = 2'd2,
      SQ_IDLE  = 2'd3
   } seq_state_t;

   typedef enum logic [1:0] {
      SH_IDLE   = 2'd0,
      SH_LOW    = 2'd1,
      SH_HIGH   = 2'd2,
      SH_STROBE = 2'd3
   } sh_state_t;
endpackage

// File: rtl/caldac_shadow.sv
`timescale 1ns/1ps
module caldac_shadow #(
   parameter int CHAN_W   = 4,
   parameter int VAL_W    = 8,
   parameter int NUM_CHAN = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CHAN_W-1:0] wr_chan,
   input  logic [VAL_W-1:0]  wr_val,
   input  logic [CHAN_W-1:0] rd_chan,
   output logic [VAL_W-1:0]  rd_val,
   input  logic [CHAN_W-1:0] cmp_chan,
   input  logic [VAL_W-1:0]  cmp_val,
   output logic              cmp_eq
);
   localparam logic [VAL_W-1:0] MID = {1'b1, {(VAL_W-1){1'b0}}};

   logic [VAL_W-1:0] mem [NUM_CHAN];

   for (genvar g = 0; g < NUM_CHAN; g++) begin : g_ch
      localparam logic [CHAN_W-1:0] IDX = CHAN_W'(g);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[g] <= MID;
         else if (wr_en && wr_chan == IDX)
            mem[g] <= wr_val;
      end
   end

   always_comb begin
      rd_val = '0;
      cmp_eq = 1'b0;
      for (int i = 0; i < NUM_CHAN; i++) begin
         if (rd_chan == CHAN_W'(i))
            rd_val = mem[i];
         if (cmp_chan == CHAN_W'(i))
            cmp_eq = (mem[i] == cmp_val);
      end
   end
endmodule

// File: rtl/caldac_shifter.sv
`timescale 1ns/1ps
module caldac_shifter
   import caldac_pkg::*;
#(
   parameter int FRAME_W   = 12,
   parameter int PHASE_CYC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] frame,
   output logic               sclk,
   output logic               sdata,
   output logic               load,
   output logic               done
);
   localparam int IDX_W = $clog2(FRAME_W);
   localparam int CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
   localparam logic [CNT_W-1:0] CNT_END = CNT_W'(PHASE_CYC - 1);
   localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(FRAME_W - 1);

   sh_state_t          state;
   logic [CNT_W-1:0]   cnt;
   logic [IDX_W-1:0]   idx;
   logic [FRAME_W-1:0] shreg;
   logic               phase_end;

   assign phase_end = (cnt == CNT_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SH_IDLE;
         cnt   <= '0;
         idx   <= '0;
         shreg <= '0;
      end else begin
         case (state)
            SH_IDLE: if (start) begin
               shreg <= frame;
               idx   <= IDX_TOP;
               cnt   <= '0;
               state <= SH_LOW;
            end
            SH_LOW: if (phase_end) begin
               cnt   <= '0;
               state <= SH_HIGH;
            end else cnt <= cnt + 1'b1;
            SH_HIGH: if (phase_end) begin
               cnt <= '0;
               if (idx == '0) state <= SH_STROBE;
               else begin
                  idx   <= idx - 1'b1;
                  state <= SH_LOW;
               end
            end else cnt <= cnt + 1'b1;
            SH_STROBE: if (phase_end) begin
               cnt   <= '0;
               state <= SH_IDLE;
            end else cnt <= cnt + 1'b1;
            default: state <= SH_IDLE;
         endcase
      end
   end

   assign sclk  = (state == SH_HIGH);
   assign sdata = (state == SH_LOW || state == SH_HIGH) ? shreg[idx] : 1'b0;
   assign load  = (state == SH_STROBE);
   assign done  = (state == SH_STROBE) && phase_end;
endmodule

// File: rtl/caldac_seq.sv
`timescale 1ns/1ps
module caldac_seq
   import caldac_pkg::*;
#(
   parameter int CHAN_W         = 4,
   parameter int VAL_W          = 8,
   parameter int NUM_CHAN       = 12,
   parameter int PHASE_CYC      = 2,
   parameter bit SKIP_REDUNDANT = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [CHAN_W-1:0]       req_chan,
   input  logic [VAL_W-1:0]        req_value,
   input  logic                    match,
   input  logic                    bus_gnt,
   output logic                    bus_req,
   output logic                    busy,
   output logic                    own,
   output logic                    sh_start,
   output logic [CHAN_W+VAL_W-1:0] sh_frame,
   input  logic                    sh_done,
   output logic                    wr_en,
   output logic [CHAN_W-1:0]       wr_chan,
   output logic [VAL_W-1:0]        wr_val
);
   localparam int CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
   localparam logic [CNT_W-1:0]  CNT_END  = CNT_W'(PHASE_CYC - 1);
   localparam logic [CHAN_W:0]   CH_LIMIT = (CHAN_W+1)'(NUM_CHAN);
   localparam logic [CHAN_W-1:0] LAST_CH  = CHAN_W'(NUM_CHAN - 1);
   localparam logic [VAL_W-1:0]  MID      = {1'b1, {(VAL_W-1){1'b0}}};

   seq_state_t        state;
   logic              init_mode;
   logic [CHAN_W-1:0] cur_chan;
   logic [VAL_W-1:0]  cur_val;
   logic [CNT_W-1:0]  pcnt;
   logic              chan_ok;
   logic              skip;

   assign chan_ok = ({1'b0, req_chan} < CH_LIMIT);

   if (SKIP_REDUNDANT) begin : g_skip
      assign skip = match;
   end else begin : g_noskip
      assign skip = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SQ_ARB;
         init_mode <= 1'b1;
         cur_chan  <= '0;
         cur_val   <= MID;
         pcnt      <= '0;
      end else begin
         case (state)
            SQ_IDLE: if (req_valid && chan_ok && !skip) begin
               cur_chan <= req_chan;
               cur_val  <= req_value;
               state    <= SQ_ARB;
            end
            SQ_ARB: if (bus_gnt) begin
               pcnt  <= '0;
               state <= SQ_PREP;
            end
            SQ_PREP: if (pcnt == CNT_END) begin
               pcnt  <= '0;
               state <= SQ_SHIFT;
            end else pcnt <= pcnt + 1'b1;
            SQ_SHIFT: if (sh_done) begin
               if (init_mode && cur_chan != LAST_CH) begin
                  cur_chan <= cur_chan + 1'b1;
                  state    <= SQ_ARB;
               end else begin
                  init_mode <= 1'b0;
                  state     <= SQ_IDLE;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign busy     = (state != SQ_IDLE);
   assign bus_req  = (state != SQ_IDLE);
   assign own      = (state == SQ_PREP) || (state == SQ_SHIFT);
   assign sh_start = (state == SQ_PREP) && (pcnt == CNT_END);
   assign sh_frame = {cur_chan, cur_val};
   assign wr_en    = (state == SQ_SHIFT) && sh_done;
   assign wr_chan  = cur_chan;
   assign wr_val   = cur_val;
endmodule

// File: rtl/caldac_loader.sv
`timescale 1ns/1ps
module caldac_loader #(
   parameter int CHAN_W         = 4,
   parameter int VAL_W          = 8,
   parameter int NUM_CHAN       = 12,
   parameter int PHASE_CYC      = 2,
   parameter bit SKIP_REDUNDANT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [CHAN_W-1:0] req_chan,
   input  logic [VAL_W-1:0]  req_value,
   output logic              busy,
   input  logic [CHAN_W-1:0] rd_chan,
   output logic [VAL_W-1:0]  rd_value,
   output logic              bus_req,
   input  logic              bus_gnt,
   input  logic              ext_sclk,
   input  logic              ext_sdata,
   input  logic              ext_cs,
   input  logic              ext_wp_rel,
   output logic              ser_clk,
   output logic              ser_data,
   output logic              eep_cs,
   output logic              eep_wp_rel,
   output logic              dac_load
);
   localparam int FRAME_W = CHAN_W + VAL_W;

   if (NUM_CHAN < 1 || NUM_CHAN > (1 << CHAN_W)) begin : g_bad_chan
      initial $fatal(1, "caldac_loader: NUM_CHAN out of range for CHAN_W");
   end
   if (PHASE_CYC < 1 || VAL_W < 2) begin : g_bad_timing
      initial $fatal(1, "caldac_loader: PHASE_CYC or VAL_W too small");
   end

   logic               own;
   logic               match;
   logic               sh_start;
   logic               sh_done;
   logic [FRAME_W-1:0] sh_frame;
   logic               sh_sclk;
   logic               sh_sdata;
   logic               wr_en;
   logic [CHAN_W-1:0]  wr_chan;
   logic [VAL_W-1:0]   wr_val;

   caldac_shadow #(
      .CHAN_W(CHAN_W), .VAL_W(VAL_W), .NUM_CHAN(NUM_CHAN)
   ) u_shadow (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_chan(wr_chan), .wr_val(wr_val),
      .rd_chan(rd_chan), .rd_val(rd_value),
      .cmp_chan(req_chan), .cmp_val(req_value), .cmp_eq(match)
   );

   caldac_seq #(
      .CHAN_W(CHAN_W), .VAL_W(VAL_W), .NUM_CHAN(NUM_CHAN),
      .PHASE_CYC(PHASE_CYC), .SKIP_REDUNDANT(SKIP_REDUNDANT)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_chan(req_chan), .req_value(req_value),
      .match(match), .bus_gnt(bus_gnt), .bus_req(bus_req),
      .busy(busy), .own(own),
      .sh_start(sh_start), .sh_frame(sh_frame), .sh_done(sh_done),
      .wr_en(wr_en), .wr_chan(wr_chan), .wr_val(wr_val)
   );

   caldac_shifter #(
      .FRAME_W(FRAME_W), .PHASE_CYC(PHASE_CYC)
   ) u_shift (
      .clk(clk), .rst_n(rst_n),
      .start(sh_start), .frame(sh_frame),
      .sclk(sh_sclk), .sdata(sh_sdata), .load(dac_load), .done(sh_done)
   );

   always_comb begin
      if (own) begin
         ser_clk    = sh_sclk;
         ser_data   = sh_sdata;
         eep_cs     = 1'b0;
         eep_wp_rel = 1'b0;
      end else begin
         ser_clk    = ext_sclk;
         ser_data   = ext_sdata;
         eep_cs     = ext_cs;
         eep_wp_rel = ext_wp_rel;
      end
   end
endmodule

// File: rtl/caldac_loader_chk.sv
`timescale 1ns/1ps
module caldac_loader_chk (
   input logic clk,
   input logic rst_n,
   input logic own,
   input logic busy,
   input logic bus_req,
   input logic bus_gnt,
   input logic ser_clk,
   input logic ser_data,
   input logic eep_cs,
   input logic eep_wp_rel,
   input logic dac_load
);
   // R2
   data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (own && $past(own) && ser_clk && $past(ser_clk)) |-> $stable(ser_data));

   // R3
   lines_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      own |-> (!eep_cs && !eep_wp_rel));

   // R4
   strobe_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dac_load |-> !ser_clk);

   // R8
   load_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dac_load |-> busy);

   // R8
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $fell(dac_load));

   // R9
   owned_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      own |-> (bus_gnt && bus_req));
endmodule

bind caldac_loader caldac_loader_chk u_chk (
   .clk(clk), .rst_n(rst_n), .own(own), .busy(busy),
   .bus_req(bus_req), .bus_gnt(bus_gnt),
   .ser_clk(ser_clk), .ser_data(ser_data),
   .eep_cs(eep_cs), .eep_wp_rel(eep_wp_rel), .dac_load(dac_load)
);

// File: tb/caldac_loader_test.sv
`timescale 1ns/1ps
module caldac_loader_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [3:0] req_chan = '0;
   logic [7:0] req_value = '0;
   logic [3:0] rd_chan = '0;
   logic       bus_gnt = 1'b0;
   logic       ext_sclk = 1'b0, ext_sdata = 1'b0, ext_cs = 1'b0, ext_wp_rel = 1'b0;
   logic       busy, bus_req, ser_clk, ser_data, eep_cs, eep_wp_rel, dac_load;
   logic [7:0] rd_value;

   int vectors = 0;
   int miscompares = 0;
   bit allow_gnt = 1'b1;

   // frame monitor state
   logic [11:0] cap = '0;
   int  nbits = 0, rises = 0, bits_at_load = 0, nlog = 0, line_viol = 0;
   logic [11:0] log_word [64];
   int  log_bits [64];
   logic log_busy [64];
   logic prev_sclk = 1'b0, prev_load = 1'b0;

   caldac_loader uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
      .req_value(req_value), .busy(busy), .rd_chan(rd_chan), .rd_value(rd_value),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .ext_sclk(ext_sclk),
      .ext_sdata(ext_sdata), .ext_cs(ext_cs), .ext_wp_rel(ext_wp_rel),
      .ser_clk(ser_clk), .ser_data(ser_data), .eep_cs(eep_cs),
      .eep_wp_rel(eep_wp_rel), .dac_load(dac_load)
   );

   always #2.5 clk = ~clk;

   // arbiter model: grant follows request half a cycle later
   always @(negedge clk) bus_gnt <= bus_req && allow_gnt;

   always @(negedge clk) begin
      if (!dac_load && prev_load) begin
         if (nlog < 64) begin
            log_word[nlog] = cap;
            log_bits[nlog] = bits_at_load;
            log_busy[nlog] = busy;
         end
         nlog = nlog + 1;
         nbits = 0;
         cap = '0;
      end
      if (dac_load && !prev_load) bits_at_load = nbits;
      if (bus_gnt && ser_clk && !prev_sclk && !dac_load && !prev_load) begin
         cap = {cap[10:0], ser_data};
         nbits = nbits + 1;
         rises = rises + 1;
         if (eep_cs || eep_wp_rel) line_viol = line_viol + 1;
      end
      prev_sclk = ser_clk;
      prev_load = dac_load;
   end

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 20000) begin
         @(negedge clk);
         n++;
      end
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic issue(input logic [3:0] ch, input logic [7:0] v);
      @(negedge clk);
      req_valid = 1'b1;
      req_chan  = ch;
      req_value = v;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   function automatic int readback(input logic [3:0] ch);
      return 0;
   endfunction

   task automatic rd(input logic [3:0] ch, output int v);
      rd_chan = ch;
      #1;
      v = int'(rd_value);
   endtask

   task automatic t_init();
      int v;
      @(negedge clk);
      check("R6 busy after reset", int'(busy), 1);
      check("R9 bus_req after reset", int'(bus_req), 1);
      wait_idle();
      check("R6 init frame count", nlog, 12);
      for (int i = 0; i < 12; i++) begin
         check("R6 init frame word", int'(log_word[i]), (i << 8) | 'h80);
         check("R1 init frame bits", log_bits[i], 12);
      end
      for (int i = 0; i < 12; i++) begin
         rd(4'(i), v);
         check("R7 readback after init", v, 'h80);
      end
      rd(4'd13, v);
      check("R7 readback out of range", v, 0);
   endtask

   task automatic t_write(input logic [3:0] ch, input logic [7:0] v);
      int n0 = nlog;
      int r;
      issue(ch, v);
      check("R8 busy after accept", int'(busy), 1);
      wait_idle();
      check("R1 one frame", nlog - n0, 1);
      check("R1 frame word", int'(log_word[n0]), int'({ch, v}));
      check("R4 strobe after 12 bits", log_bits[n0], 12);
      check("R8 busy low as load falls", int'(log_busy[n0]), 0);
      rd(ch, r);
      check("R7 readback after load", r, int'(v));
   endtask

   task automatic t_skip();
      int n0 = nlog, r0 = rises;
      issue(4'd3, 8'h5A);
      check("R5 busy stays low", int'(busy), 0);
      repeat (60) @(negedge clk);
      check("R5 no frame", nlog - n0, 0);
      check("R5 no clock edge", rises - r0, 0);
   endtask

   task automatic t_ignore();
      int n0 = nlog, r;
      issue(4'd5, 8'h77);
      issue(4'd6, 8'h99);
      wait_idle();
      check("R8 only first request loaded", nlog - n0, 1);
      check("R8 first frame word", int'(log_word[n0]), int'({4'd5, 8'h77}));
      rd(4'd6, r);
      check("R8 ignored channel unchanged", r, 'h80);
   endtask

   task automatic t_range();
      int n0 = nlog, r0 = rises;
      issue(4'd13, 8'h12);
      check("R11 busy stays low", int'(busy), 0);
      repeat (60) @(negedge clk);
      check("R11 no frame", nlog - n0, 0);
      check("R11 no clock edge", rises - r0, 0);
   endtask

   task automatic t_arb();
      int n0 = nlog, r0 = rises;
      allow_gnt = 1'b0;
      ext_sclk = 1'b1; ext_sdata = 1'b1; ext_cs = 1'b1; ext_wp_rel = 1'b0;
      issue(4'd7, 8'hAB);
      repeat (30) @(negedge clk);
      check("R9 waits for grant", rises - r0, 0);
      check("R9 bus_req held", int'(bus_req), 1);
      check("R10 passthrough sclk", int'(ser_clk), 1);
      check("R10 passthrough cs", int'(eep_cs), 1);
      check("R10 passthrough wp", int'(eep_wp_rel), 0);
      ext_sclk = 1'b0; ext_sdata = 1'b0; ext_cs = 1'b0;
      allow_gnt = 1'b1;
      wait_idle();
      check("R9 frame after grant", int'(log_word[n0]), int'({4'd7, 8'hAB}));
   endtask

   task automatic t_lines();
      int v0 = line_viol;
      ext_cs = 1'b1; ext_wp_rel = 1'b1; ext_sdata = 1'b1;
      t_write(4'd9, 8'h3C);
      check("R3 memory lines forced low", line_viol - v0, 0);
      check("R10 idle passthrough cs", int'(eep_cs), 1);
      check("R10 idle passthrough wp", int'(eep_wp_rel), 1);
      check("R10 idle passthrough data", int'(ser_data), 1);
      ext_cs = 1'b0; ext_wp_rel = 1'b0; ext_sdata = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_init();
      t_write(4'd3, 8'h5A);
      t_write(4'd11, 8'hC3);
      t_write(4'd0, 8'h01);
      t_skip();
      t_ignore();
      t_range();
      t_arb();
      t_lines();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule